// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit decides, for the instruction sitting in the decode stage of a five-stage in-order integer pipeline, where each of its two ALU operands must come from once it reaches execute. It also decides whether the pipeline must hold for one cycle. The two source register numbers are read from the fetch/decode register. The destination numbers, write enables and the load flag of the two instructions ahead of it are read from the decode/execute and execute/memory registers. The resulting operand selects are registered, so they reach the execute stage together with the instruction they belong to.

A source that matches the result about to leave execute is taken from the execute/memory register on the following cycle. A source that matches the result about to leave memory is taken from the memory/writeback register. A result that is already in writeback needs no help, because the register file writes in the first half of a cycle and reads in the second. A load whose result is wanted by the very next instruction cannot be forwarded in time. For that case the unit raises a hold request, which keeps the PC and the fetch/decode register unchanged. It also raises a kill request, which makes the decode/execute register take in a do-nothing control word. On the next cycle the load has moved one stage on, and its data is forwarded from the memory/writeback register.

Top module: `hazard_interlock`

## Requirements
- R1: A used, nonzero source that equals the destination of an enabled, non-load instruction in decode/execute makes that operand's select read 2'b10 (take from execute/memory) on the cycle after the clock edge.
- R2: A used, nonzero source that matches only the enabled destination in execute/memory makes that operand's select read 2'b01 (take from memory/writeback) on the cycle after the clock edge.
- R3: When both later stages match the same source, the select reads 2'b10, because the younger result wins.
- R4: A used, nonzero source that equals the destination of an enabled load in decode/execute raises `hold` and `kill` in the same cycle. Both operand selects read 2'b00 on the cycle after that clock edge.
- R5: Once the pipeline has advanced, the load sits in execute/memory and a bubble sits in decode/execute. In that position the dependent instruction raises no hold, and its select reads 2'b01. The interlock therefore lasts exactly one cycle.
- R6: With the zero-register option on (default), register 0 as a source never causes a hold or a select other than 2'b00.
- R7: A stage whose write enable is low never causes a hold or a forward, whatever its destination and load flag.
- R8: When no later stage matches, the select reads 2'b00 (register file) and `hold` stays low.
- R9: When both sources name the same register, both selects are forwarded alike, and a load match on it raises `hold`.
- R10: A source whose used flag is low never causes a hold or a forward. A store's base register counts as a used source.
- R11: During and right after reset, both selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | First source register number in fetch/decode |
| id_rs2 | input | AW | Second source register number in fetch/decode |
| id_rs1_used | input | 1 | First source is read (ALU operand or store base) |
| id_rs2_used | input | 1 | Second source is read |
| ex_rd | input | AW | Destination in decode/execute |
| ex_wen | input | 1 | Register write enable in decode/execute |
| ex_is_load | input | 1 | Instruction in decode/execute is a load |
| mem_rd | input | AW | Destination in execute/memory |
| mem_wen | input | 1 | Register write enable in execute/memory |
| hold | output | 1 | Keep PC and fetch/decode register unchanged |
| kill | output | 1 | Load a do-nothing control word into decode/execute |
| ex_fwd_a | output | 2 | Operand A select for execute: 00 regfile, 01 mem/wb, 10 ex/mem |
| ex_fwd_b | output | 2 | Operand B select for execute: same code |

## Verification
The bench builds the unit with two-bit register numbers and the zero-register option on. At that size, every combination of source numbers, used flags, both destinations, both write enables and the load flag can be driven: 16384 vectors. Register 0 colliding with a destination, the same register on both operands, both stages matching at once, and disabled writers are therefore all covered rather than sampled. A short directed sequence then moves a load and its consumer through two pipeline positions to show that the hold lasts one cycle and is followed by the memory/writeback forward.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_MEMWB   = 2'b01,
      SEL_EXMEM   = 2'b10
   } opnd_sel_e;
   localparam int SEL_W = 2;
endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
   parameter int AW        = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic          src_used,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   output logic          hit_ex,
   output logic          hit_mem
);
   logic live;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign live = src_used && (src != '0);
      end else begin : g_zero_soft
         assign live = src_used;
      end
   endgenerate

   assign hit_ex  = live && ex_wen  && (ex_rd  == src);
   assign hit_mem = live && mem_wen && (mem_rd == src);
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
(
   input  logic      hit_ex,
   input  logic      hit_mem,
   input  logic      ex_is_load,
   output opnd_sel_e sel,
   output logic      load_use
);
   always_comb begin
      load_use = hit_ex && ex_is_load;
      if (hit_ex)       sel = SEL_EXMEM;
      else if (hit_mem) sel = SEL_MEMWB;
      else              sel = SEL_REGFILE;
   end
endmodule

// File: rtl/hzd_sel_reg.sv
module hzd_sel_reg #(
   parameter int NSRC = 2,
   parameter int SW   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill,
   input  logic [NSRC*SW-1:0] sel_d,
   output logic [NSRC*SW-1:0] sel_q
);
   for (genvar s = 0; s < NSRC; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sel_q[s*SW +: SW] <= '0;
         else if (kill) sel_q[s*SW +: SW] <= '0;
         else           sel_q[s*SW +: SW] <= sel_d[s*SW +: SW];
      end
   end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
   import hzd_pkg::*;
#(
   parameter int AW        = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic          id_rs1_used,
   input  logic          id_rs2_used,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic          ex_is_load,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   output logic          hold,
   output logic          kill,
   output logic [1:0]    ex_fwd_a,
   output logic [1:0]    ex_fwd_b
);
   localparam int NSRC = 2;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("hazard_interlock: AW must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0][AW-1:0] src;
   logic [NSRC-1:0]         used;
   logic [NSRC-1:0]         hit_ex, hit_mem, load_use;
   opnd_sel_e [NSRC-1:0]    sel;
   logic [NSRC*SEL_W-1:0]   sel_d, sel_q;

   assign src[0]  = id_rs1;
   assign src[1]  = id_rs2;
   assign used[0] = id_rs1_used;
   assign used[1] = id_rs2_used;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      hzd_src_cmp #(.AW(AW), .ZERO_HARD(ZERO_HARD)) u_cmp (
         .src     (src[s]),
         .src_used(used[s]),
         .ex_rd   (ex_rd),
         .ex_wen  (ex_wen),
         .mem_rd  (mem_rd),
         .mem_wen (mem_wen),
         .hit_ex  (hit_ex[s]),
         .hit_mem (hit_mem[s])
      );
      hzd_fwd_pick u_pick (
         .hit_ex    (hit_ex[s]),
         .hit_mem   (hit_mem[s]),
         .ex_is_load(ex_is_load),
         .sel       (sel[s]),
         .load_use  (load_use[s])
      );
      assign sel_d[s*SEL_W +: SEL_W] = sel[s];
   end

   assign hold = |load_use;
   assign kill = |load_use;

   hzd_sel_reg #(.NSRC(NSRC), .SW(SEL_W)) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .kill (kill),
      .sel_d(sel_d),
      .sel_q(sel_q)
   );

   assign ex_fwd_a = sel_q[0 +: SEL_W];
   assign ex_fwd_b = sel_q[SEL_W +: SEL_W];
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
   parameter int AW        = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] id_rs1,
   input logic [AW-1:0] id_rs2,
   input logic          id_rs1_used,
   input logic          id_rs2_used,
   input logic [AW-1:0] ex_rd,
   input logic          ex_wen,
   input logic          ex_is_load,
   input logic [AW-1:0] mem_rd,
   input logic          mem_wen,
   input logic          hold,
   input logic          kill,
   input logic [1:0]    ex_fwd_a,
   input logic [1:0]    ex_fwd_b
);
   logic a_nz, b_nz;
   assign a_nz = (id_rs1 != '0) || !ZERO_HARD;
   assign b_nz = (id_rs2 != '0) || !ZERO_HARD;

   a_r1_ex_forward_a: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs1_used && a_nz && ex_wen && !ex_is_load && ex_rd == id_rs1 && !kill)
      |=> ex_fwd_a == 2'b10);

   a_r2_mem_forward_b: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs2_used && b_nz && mem_wen && mem_rd == id_rs2
       && !(ex_wen && ex_rd == id_rs2) && !kill)
      |=> ex_fwd_b == 2'b01);

   a_r4_bubble_clears_selects: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));

   a_r4_load_use_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs1_used && a_nz && ex_wen && ex_is_load && ex_rd == id_rs1) |-> hold);

   a_r7_disabled_writer_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_wen |-> !hold);

   a_r10_unused_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_rs1_used && !id_rs2_used) |-> !hold);

   generate
      if (ZERO_HARD) begin : g_zero
         a_r6_zero_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (id_rs1 == '0 && id_rs2 == '0) |-> !hold);
      end
   endgenerate
endmodule

bind hazard_interlock hazard_interlock_chk #(.AW(AW), .ZERO_HARD(ZERO_HARD)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
   .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
   .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
   .mem_rd(mem_rd), .mem_wen(mem_wen), .hold(hold), .kill(kill),
   .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
);

// File: tb/test_hazard_interlock.sv
`timescale 1ns/1ps
module test_hazard_interlock;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
   logic          id_rs1_used = 1'b0, id_rs2_used = 1'b0;
   logic          ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0;
   logic          hold, kill;
   logic [1:0]    ex_fwd_a, ex_fwd_b;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hazard_interlock #(.AW(AW), .ZERO_HARD(1'b1)) i_hazard_interlock (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
      .mem_rd(mem_rd), .mem_wen(mem_wen),
      .hold(hold), .kill(kill), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (rs1=%0d rs2=%0d u=%b%b exrd=%0d w=%b ld=%b memrd=%0d w=%b)",
                  req, act, exp, id_rs1, id_rs2, id_rs1_used, id_rs2_used,
                  ex_rd, ex_wen, ex_is_load, mem_rd, mem_wen);
      end
   endtask

   function automatic bit hit(input int s, input bit u, input int rd, input bit w);
      return u && (s != 0) && w && (rd == s);
   endfunction

   function automatic int exp_sel(input bit hx, input bit hm, input bit stall);
      if (stall)   return 0;
      if (hx)      return 2;
      if (hm)      return 1;
      return 0;
   endfunction

   function automatic string tag(input int s, input bit u, input bit hx, input bit hm,
                                 input bit same, input bit stall);
      if (stall)          return "R4";
      if (!u)             return "R10";
      if (s == 0)         return "R6";
      if (same)           return "R9";
      if (hx && hm)       return "R3";
      if (hx)             return "R1";
      if (hm)             return "R2";
      if (!ex_wen || !mem_wen) return "R7";
      return "R8";
   endfunction

   initial begin
      // R11: reset state
      #1;
      check("R11", ex_fwd_a, 0);
      check("R11", ex_fwd_b, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R11", {ex_fwd_a, ex_fwd_b}, 0);

      // Exhaustive sweep
      for (int v = 0; v < (1 << 14); v++) begin
         bit hxa, hma, hxb, hmb, st, same;
         @(negedge clk);
         id_rs1      = v[1:0];
         id_rs2      = v[3:2];
         id_rs1_used = v[4];
         id_rs2_used = v[5];
         ex_rd       = v[7:6];
         ex_wen      = v[8];
         ex_is_load  = v[9];
         mem_rd      = v[11:10];
         mem_wen     = v[12];
         if (v[13]) begin
            id_rs2 = id_rs1; id_rs2_used = id_rs1_used;
         end
         hxa  = hit(id_rs1, id_rs1_used, ex_rd, ex_wen);
         hma  = hit(id_rs1, id_rs1_used, mem_rd, mem_wen);
         hxb  = hit(id_rs2, id_rs2_used, ex_rd, ex_wen);
         hmb  = hit(id_rs2, id_rs2_used, mem_rd, mem_wen);
         st   = ex_is_load && (hxa || hxb);
         same = (id_rs1 == id_rs2) && id_rs1_used && id_rs2_used;
         #1;
         check(st ? "R4" : "R8", {hold, kill}, st ? 3 : 0);
         @(posedge clk);
         #1;
         check(tag(id_rs1, id_rs1_used, hxa, hma, same, st), ex_fwd_a, exp_sel(hxa, hma, st));
         check(tag(id_rs2, id_rs2_used, hxb, hmb, same, st), ex_fwd_b, exp_sel(hxb, hmb, st));
      end

      // R5: load r1 then consumer reading r1 on both operands (R9)
      @(negedge clk);
      id_rs1 = 2'd1; id_rs2 = 2'd1; id_rs1_used = 1'b1; id_rs2_used = 1'b1;
      ex_rd = 2'd1; ex_wen = 1'b1; ex_is_load = 1'b1;
      mem_rd = 2'd3; mem_wen = 1'b0;
      #1;
      check("R5", hold, 1);
      @(posedge clk); #1;
      check("R5", {ex_fwd_a, ex_fwd_b}, 0);
      @(negedge clk);
      ex_rd = 2'd0; ex_wen = 1'b0; ex_is_load = 1'b0;
      mem_rd = 2'd1; mem_wen = 1'b1;
      #1;
      check("R5", hold, 0);
      @(posedge clk); #1;
      check("R5", ex_fwd_a, 1);
      check("R9", ex_fwd_b, 1);

      // R10: store base in rs1 used, data source unused matching a load
      @(negedge clk);
      id_rs1 = 2'd2; id_rs1_used = 1'b1; id_rs2 = 2'd3; id_rs2_used = 1'b0;
      ex_rd = 2'd3; ex_wen = 1'b1; ex_is_load = 1'b1; mem_rd = 2'd2; mem_wen = 1'b1;
      #1;
      check("R10", hold, 0);
      @(posedge clk); #1;
      check("R10", ex_fwd_a, 1);
      check("R10", ex_fwd_b, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (40000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule